// File: doc/BRIEF.md
# Floppy Controller Interrupt Status Unit

This unit holds the interrupt-status side of a floppy disk controller's command engine for four drives. Each drive has a pending flag, a latched status-0 byte and a present-cylinder register. Conditions come from two sources. One is polling after a reset: the unit queues a drive-change condition on every drive. The other is seek completion: a seek-done event sets the flag of one drive. The interrupt request stays high while any condition is pending.

Software answers the interrupt with the sense-interrupt command byte. The unit services the lowest-numbered pending drive. It returns two result bytes, status 0 and then that drive's cylinder, and it clears that drive's flag. If nothing is pending, the command is invalid and gets a single error byte. Any other opcode is also answered as invalid. A configuration strobe switches polling off, so that a later controller reset queues nothing. The asynchronous reset returns polling to on.

Top module: `fdc_intstat`

## Requirements
- R1: After asynchronous reset, all four drives are pending, every cylinder register reads 0, polling is on, `irq` is 1, `cmd_ready` is 1 and `res_valid` is 0.
- R2: A sense command (opcode 0x08) with conditions pending returns two bytes. The first is status 0 and the second is the serviced drive's cylinder. After a reset with polling on, the status bytes are 0xC0, 0xC1, 0xC2 and 0xC3 for drives 0 to 3: bits 7:6 = 11 mark a drive-status change and bits 1:0 give the drive. The seek-end bit 0x20 is clear in these bytes.
- R3: A one-cycle `soft_rst` pulse while polling is on discards pending conditions and any result in progress. It zeroes all cylinder registers and queues the four drive-change conditions of R2.
- R4: `cfg_we` with `cfg_poll_en`=0 turns polling off. A later `soft_rst` then leaves nothing pending, and `irq` stays 0.
- R5: A sense command with nothing pending returns the single byte 0x80 and leaves every pending flag unchanged.
- R6: Any opcode other than 0x08 returns the single byte 0x80 and leaves every pending flag unchanged.
- R7: A `seek_vld` event for drive d makes d pending, latches `seek_cyl` as its cylinder and sets status 0 to 0x20+d. When `seek_err` is 1 the status is 0x60+d.
- R8: When several drives are pending, the drive with the lowest number is serviced first.
- R9: `irq` is 1 exactly while any condition is pending. It falls in the cycle after the sense command that consumes the last condition is accepted.
- R10: While `res_valid` is 1 and `res_ready` is 0, `res_byte` holds its value.
- R11: Asynchronous reset sets polling back to on even when it had been turned off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Controller reset pulse (synchronous) |
| cfg_we | input | 1 | Strobe that writes the polling enable |
| cfg_poll_en | input | 1 | New polling enable value |
| seek_vld | input | 1 | Seek-done event |
| seek_drv | input | 2 | Drive that finished seeking |
| seek_err | input | 1 | The seek ended abnormally |
| seek_cyl | input | 8 | Cylinder reached by the seek |
| cmd_valid | input | 1 | Command byte offered |
| cmd_byte | input | 8 | Command opcode |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| res_valid | output | 1 | Result byte offered |
| res_byte | output | 8 | Result byte |
| res_ready | input | 1 | Host takes the result byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with its default values: four drives and 8-bit cylinders. With four drives, the post-reset polling sequence runs to its full length, and the table of seek vectors reaches both the top drive index and a cylinder value of all ones. The cases where a seek status and a polling status compete in the same drive register are also within reach.

// File: rtl/fdc_is_pkg.sv
package fdc_is_pkg;
  localparam logic [7:0] SENSE_OP  = 8'h08;
  localparam logic [7:0] BAD_CMD   = 8'h80;

  typedef enum logic [1:0] {RS_IDLE, RS_FIRST, RS_SECOND} res_state_t;

  // status 0 for a polling drive-change condition
  function automatic logic [7:0] st0_poll(input logic [7:0] drv);
    return 8'hC0 | (drv & 8'h03);
  endfunction

  // status 0 for a finished seek, abnormal end adds bit 6
  function automatic logic [7:0] st0_seek(input logic [7:0] drv, input logic err);
    return 8'h20 | (err ? 8'h40 : 8'h00) | (drv & 8'h03);
  endfunction
endpackage

// File: rtl/fdc_is_pending.sv
module fdc_is_pending
  import fdc_is_pkg::*;
#(
  parameter int NDRV = 4,
  parameter int CW   = 8,
  localparam int DW  = $clog2(NDRV)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     soft_rst,
  input  logic                     poll_en,
  input  logic                     seek_vld,
  input  logic [DW-1:0]            seek_drv,
  input  logic                     seek_err,
  input  logic [CW-1:0]            seek_cyl,
  input  logic [NDRV-1:0]          clr_vec,
  output logic [NDRV-1:0]          pend,
  output logic [NDRV-1:0][7:0]     st0_arr,
  output logic [NDRV-1:0][CW-1:0]  cyl_arr
);
  for (genvar d = 0; d < NDRV; d++) begin : g_drv
    logic seek_hit;
    assign seek_hit = seek_vld && (seek_drv == DW'(d));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[d]    <= 1'b1;
        st0_arr[d] <= st0_poll(8'(d));
        cyl_arr[d] <= '0;
      end else if (soft_rst) begin
        pend[d]    <= poll_en;
        st0_arr[d] <= st0_poll(8'(d));
        cyl_arr[d] <= '0;
      end else if (seek_hit) begin
        pend[d]    <= 1'b1;
        st0_arr[d] <= st0_seek(8'(d), seek_err);
        cyl_arr[d] <= seek_cyl;
      end else if (clr_vec[d]) begin
        pend[d]    <= 1'b0;
      end
    end
  end

  // R7
  seek_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seek_vld && !soft_rst |=> pend[$past(seek_drv)]);
  // R4
  poll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && !poll_en |=> pend == '0);
  // R3
  poll_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst && poll_en |=> &pend);
endmodule

// File: rtl/fdc_is_arbiter.sv
module fdc_is_arbiter #(
  parameter int NDRV = 4,
  localparam int DW  = $clog2(NDRV)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDRV-1:0] pend,
  output logic            any_pend,
  output logic [DW-1:0]   svc_drv
);
  assign any_pend = |pend;

  always_comb begin
    svc_drv = '0;
    for (int i = NDRV - 1; i >= 0; i--) begin
      if (pend[i]) svc_drv = DW'(i);
    end
  end

  // R8
  lowest_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_pend |-> pend[svc_drv] &&
      ((pend & ((NDRV'(1) << svc_drv) - NDRV'(1))) == '0));
endmodule

// File: rtl/fdc_is_result.sv
module fdc_is_result
  import fdc_is_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       accept,
  input  logic       two_bytes,
  input  logic [7:0] byte0,
  input  logic [7:0] byte1,
  output logic       cmd_ready,
  output logic       res_valid,
  output logic [7:0] res_byte,
  input  logic       res_ready
);
  res_state_t st;
  logic [7:0] b0_q, b1_q;
  logic       two_q;

  assign cmd_ready = (st == RS_IDLE);
  assign res_valid = (st != RS_IDLE);
  assign res_byte  = (st == RS_SECOND) ? b1_q : b0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RS_IDLE;
      b0_q <= '0;
      b1_q <= '0;
      two_q <= 1'b0;
    end else if (soft_rst) begin
      st <= RS_IDLE;
    end else begin
      case (st)
        RS_IDLE: if (accept) begin
          st    <= RS_FIRST;
          b0_q  <= byte0;
          b1_q  <= byte1;
          two_q <= two_bytes;
        end
        RS_FIRST:  if (res_ready) st <= two_q ? RS_SECOND : RS_IDLE;
        RS_SECOND: if (res_ready) st <= RS_IDLE;
        default:   st <= RS_IDLE;
      endcase
    end
  end

  // R10
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready && !soft_rst |=> res_valid && $stable(res_byte));
endmodule

// File: rtl/fdc_intstat.sv
module fdc_intstat
  import fdc_is_pkg::*;
#(
  parameter int NDRV = 4,
  parameter int CW   = 8,
  localparam int DW  = $clog2(NDRV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          cfg_we,
  input  logic          cfg_poll_en,
  input  logic          seek_vld,
  input  logic [DW-1:0] seek_drv,
  input  logic          seek_err,
  input  logic [CW-1:0] seek_cyl,
  input  logic          cmd_valid,
  input  logic [7:0]    cmd_byte,
  output logic          cmd_ready,
  output logic          res_valid,
  output logic [7:0]    res_byte,
  input  logic          res_ready,
  output logic          irq
);
  logic                    poll_en;
  logic [NDRV-1:0]         pend;
  logic [NDRV-1:0][7:0]    st0_arr;
  logic [NDRV-1:0][CW-1:0] cyl_arr;
  logic [NDRV-1:0]         clr_vec;
  logic                    any_pend;
  logic [DW-1:0]           svc_drv;
  logic                    cmd_accept;
  logic                    sense_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      poll_en <= 1'b1;
    else if (cfg_we) poll_en <= cfg_poll_en;
  end

  assign cmd_accept = cmd_valid && cmd_ready && !soft_rst;
  assign sense_hit  = cmd_accept && (cmd_byte == SENSE_OP) && any_pend;
  assign clr_vec    = sense_hit ? (NDRV'(1) << svc_drv) : '0;
  assign irq        = any_pend;

  fdc_is_pending #(.NDRV(NDRV), .CW(CW)) u_pend (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .poll_en(poll_en),
    .seek_vld(seek_vld), .seek_drv(seek_drv), .seek_err(seek_err),
    .seek_cyl(seek_cyl), .clr_vec(clr_vec), .pend(pend),
    .st0_arr(st0_arr), .cyl_arr(cyl_arr)
  );

  fdc_is_arbiter #(.NDRV(NDRV)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend),
    .any_pend(any_pend), .svc_drv(svc_drv)
  );

  fdc_is_result u_res (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .accept(cmd_accept),
    .two_bytes(sense_hit),
    .byte0(sense_hit ? st0_arr[svc_drv] : BAD_CMD),
    .byte1(8'(cyl_arr[svc_drv])),
    .cmd_ready(cmd_ready), .res_valid(res_valid), .res_byte(res_byte),
    .res_ready(res_ready)
  );

  // R5 R6
  invalid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept && !sense_hit && !seek_vld |=> pend == $past(pend));
  // R9
  clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));
  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sense_hit && $countones(pend) == 1 && !seek_vld |=> !irq);
endmodule

// File: tb/sim_fdc_intstat.sv
module sim_fdc_intstat;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 0, cfg_we = 0, cfg_poll_en = 1;
  logic seek_vld = 0, seek_err = 0;
  logic [1:0] seek_drv = 0;
  logic [7:0] seek_cyl = 0;
  logic cmd_valid = 0;
  logic [7:0] cmd_byte = 0;
  logic cmd_ready, res_valid, res_ready = 0, irq;
  logic [7:0] res_byte;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_intstat u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_poll_en(cfg_poll_en), .seek_vld(seek_vld), .seek_drv(seek_drv),
    .seek_err(seek_err), .seek_cyl(seek_cyl), .cmd_valid(cmd_valid),
    .cmd_byte(cmd_byte), .cmd_ready(cmd_ready), .res_valid(res_valid),
    .res_byte(res_byte), .res_ready(res_ready), .irq(irq)
  );

  // {drive, err, cylinder, expected status 0}
  localparam logic [31:0] TV [6] = '{
    32'h00_00_05_20, 32'h01_01_4F_61, 32'h02_00_27_22,
    32'h03_01_00_63, 32'h03_00_FF_23, 32'h00_01_10_60
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [7:0] op);
    @(negedge clk);
    cmd_valid = 1; cmd_byte = op;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic read_byte(output logic [7:0] b);
    for (int k = 0; k < 10 && !res_valid; k++) @(negedge clk);
    b = res_valid ? res_byte : 8'hXX;
    res_ready = 1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 0;
  endtask

  task automatic sense2(input string tag, input logic [7:0] e0, input logic [7:0] e1);
    logic [7:0] b;
    send_cmd(8'h08);
    read_byte(b); chk({tag, " st0"}, b, e0);
    read_byte(b); chk({tag, " cyl"}, b, e1);
  endtask

  task automatic single_bad(input string tag, input logic [7:0] op);
    logic [7:0] b;
    send_cmd(op);
    read_byte(b); chk({tag, " byte"}, b, 8'h80);
    chk({tag, " one byte only"}, {7'b0, res_valid}, 8'h00);
  endtask

  task automatic seek(input logic [1:0] d, input logic e, input logic [7:0] c);
    @(negedge clk);
    seek_vld = 1; seek_drv = d; seek_err = e; seek_cyl = c;
    @(negedge clk);
    seek_vld = 0;
  endtask

  task automatic pulse_soft;
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 2000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h01);
    chk("R1 cmd_ready", {7'b0, cmd_ready}, 8'h01);
    chk("R1 res_valid", {7'b0, res_valid}, 8'h00);

    // R2 polling sequence, R9 irq tracking
    for (int d = 0; d < 4; d++) begin
      sense2("R2 poll", 8'hC0 + 8'(d), 8'h00);
      chk("R9 irq after sense", {7'b0, irq}, (d == 3) ? 8'h00 : 8'h01);
    end

    // R5 sense with nothing pending
    single_bad("R5 empty sense", 8'h08);
    chk("R5 irq stays low", {7'b0, irq}, 8'h00);

    // R7 seek vectors from table
    for (int i = 0; i < 6; i++) begin
      seek(TV[i][25:24], TV[i][16], TV[i][15:8]);
      chk("R9 irq on seek", {7'b0, irq}, 8'h01);
      sense2("R7 seek", TV[i][7:0], TV[i][15:8]);
      chk("R9 irq cleared", {7'b0, irq}, 8'h00);
    end

    // R8 ascending order
    seek(2'd3, 1'b0, 8'h33);
    seek(2'd1, 1'b0, 8'h11);
    sense2("R8 first", 8'h21, 8'h11);
    sense2("R8 second", 8'h23, 8'h33);

    // R3 soft reset with polling on clears cylinders
    pulse_soft();
    chk("R3 irq", {7'b0, irq}, 8'h01);
    for (int d = 0; d < 4; d++) sense2("R3 poll", 8'hC0 + 8'(d), 8'h00);

    // R4 polling disabled
    @(negedge clk); cfg_we = 1; cfg_poll_en = 0;
    @(negedge clk); cfg_we = 0;
    pulse_soft();
    chk("R4 irq", {7'b0, irq}, 8'h00);
    single_bad("R4 sense invalid", 8'h08);

    // R6 other opcode keeps pending
    seek(2'd2, 1'b0, 8'h07);
    single_bad("R6 other op", 8'h13);
    chk("R6 irq kept", {7'b0, irq}, 8'h01);

    // R10 hold while not ready
    send_cmd(8'h08);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10 valid held", {7'b0, res_valid}, 8'h01);
      chk("R10 byte held", res_byte, 8'h22);
    end
    begin
      logic [7:0] b;
      read_byte(b); chk("R6 st0 after other op", b, 8'h22);
      read_byte(b); chk("R6 cyl after other op", b, 8'h07);
    end

    // R11 async reset restores polling
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R11 irq", {7'b0, irq}, 8'h01);
    sense2("R11 poll", 8'hC0, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule